// File: doc/BRIEF.md
# Mode-Dependent GPIO Port Controller

This block is an eight-pin general-purpose I/O port whose pins can be borrowed by the rest of the chip, depending on a static operating-mode input. Software sees three registers on a small register bus: a direction register that can be written but never read back, an output data latch, and a pin-state view. In the external-bus modes (4, 5 and 6) the upper pins are taken over. Pin 7 carries the system clock when its direction bit is set. Pins 6 to 3 carry four bus-control strobes whatever their direction bits say. When the narrow-bus flag is set, pin 3 is released back to its direction bit. Mode 7 is single-chip and leaves every pin to the port.

The strobes and the clock are produced elsewhere. This block only routes them to the pads. It also handles two low-power states. Hardware standby reloads the direction register to its mode-dependent reset value. Software standby freezes the register contents. While in software standby, a keep option selects whether the strobe pins hold their last driven value or are released to high impedance. The register bus has no valid/ready handshake. Every access completes in the cycle it is strobed and the bus never stalls, so it has no back-pressure.

Top module: `gpio_mode_port`

## Requirements
- R1: Register select `addr` = 1 addresses the data latch, which clears to 0x00 at reset. A write with `wr_en` high is visible at the outputs after the next rising clock edge, and a read returns the stored byte.
- R2: A read of select 0, the direction register, always returns 0x00, whatever has been written to it.
- R3: Both reset and a cycle of `hw_stby` load the direction register with a value that depends on the mode. In modes 4 to 6 only bit 7 is set (0x80). In mode 7 every bit is clear (0x00).
- R4: Direction bits 2 and 1 do not exist. Pins 2 and 1 never have their output enable asserted.
- R5: While `sw_stby` is high, the direction register and the data latch keep their contents and ignore register writes.
- R6: A pin acting as a general-purpose pin drives its data-latch bit on `pin_out`, and its `pin_oe` equals its direction bit.
- R7: In modes 4 to 6, pin 7 drives `clk_src` with its output enabled when direction bit 7 is 1. When that bit is 0, pin 7 is a general-purpose pin.
- R8: In modes 4 to 6, pin k+3 drives `strobe_in[k]` (k = 0..3) with its output enabled, whatever its direction bit holds. When `bus8` is 1, pin 3 is a general-purpose pin instead.
- R9: During `sw_stby` in modes 4 to 6, the strobe pins behave according to `bus_keep`. With `bus_keep` at 0 they are released (output enable 0). With `bus_keep` at 1 they stay enabled and hold the strobe values from the last cycle before standby.
- R10: A read of select 2 returns, for each pin, one of two values. A general-purpose pin with its direction bit at 1 returns its data-latch bit. Every other pin returns `pin_in` after two synchronising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_stby | input | 1 | Hardware standby: reloads the direction register |
| sw_stby | input | 1 | Software standby: freezes the registers |
| bus_keep | input | 1 | 1 = the strobe pins keep driving in software standby |
| mode | input | 3 | Static operating mode (4..6 external bus, 7 single chip) |
| bus8 | input | 1 | Narrow external bus: returns pin 3 to the port |
| addr | input | 2 | Register select: 0 direction, 1 data, 2 pin state |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when no read is strobed |
| clk_src | input | 1 | System clock to be routed to pin 7 |
| strobe_in | input | 4 | Bus-control strobes for pins 3..6 |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |

## Verification
The hardest state to reach from the ports is strobe hold during software standby. The bench must show that the strobe pins keep the values from the last cycle before standby, while `strobe_in` changes on the very edge where standby starts. The bench drives one strobe pattern for a full cycle. On the same falling edge it then raises `sw_stby` and flips the pattern. It checks that the old pattern stays on the pins, and that the new one appears as soon as standby ends. The write-only direction register can only be observed through `pin_oe`. For that reason, every check of reset values, retention and hardware-standby reload is made on the output enables in a mode where those bits reach the pins.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PORT_W     = 8;
  localparam int ADDR_W     = 2;
  localparam int SYNC_DEPTH = 2;
  localparam int CLK_PIN    = 7;
  localparam int BUS_LO     = 3;
  localparam int BUS_N      = 4;
  localparam int BUS_HI     = BUS_LO + BUS_N - 1;

  // bits of the direction register that exist in hardware
  localparam logic [PORT_W-1:0] DIR_IMPL    = 8'b1111_1001;
  localparam logic [PORT_W-1:0] DIR_RST_EXT = 8'b1000_0000;
  localparam logic [PORT_W-1:0] DIR_RST_SC  = 8'b0000_0000;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DIR  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_PINS = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ROLE_GPIO   = 2'd0,
    ROLE_CLOCK  = 2'd1,
    ROLE_STROBE = 2'd2
  } pin_role_e;

  function automatic logic is_ext_mode(input logic [2:0] m);
    return (m == 3'd4) || (m == 3'd5) || (m == 3'd6);
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              ext_mode,
  input  logic              wr,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] dir_q
);
  logic [PORT_W-1:0] rst_val;

  assign rst_val = (ext_mode ? DIR_RST_EXT : DIR_RST_SC) & DIR_IMPL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dir_q <= rst_val;
    else if (hw_stby)
      dir_q <= rst_val;
    else if (wr && !sw_stby)
      dir_q <= wdata & DIR_IMPL;
  end

  // R3
  hw_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> dir_q == $past(rst_val));

  // R5
  sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !hw_stby) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic              bus8,
  input  logic              sw_stby,
  input  logic              bus_keep,
  input  logic [PORT_W-1:0] dir_q,
  input  logic [PORT_W-1:0] data_q,
  input  logic              clk_src,
  input  logic [BUS_N-1:0]  strobe_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic [PORT_W-1:0] gpio_drive
);
  logic [BUS_N-1:0]  strobe_hold;
  logic [PORT_W-1:0] strobe_val;
  logic              strobe_en;
  pin_role_e         role_w [PORT_W];

  // last strobe levels seen outside software standby
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      strobe_hold <= '0;
    else if (!sw_stby)
      strobe_hold <= strobe_in;
  end

  assign strobe_en = !(sw_stby && !bus_keep);

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    if (i == CLK_PIN) begin : g_clk
      assign role_w[i]     = (ext_mode && dir_q[i]) ? ROLE_CLOCK : ROLE_GPIO;
      assign strobe_val[i] = 1'b0;
    end else if (i >= BUS_LO && i <= BUS_HI) begin : g_bus
      if (i == BUS_LO) begin : g_narrow
        assign role_w[i] = (ext_mode && !bus8) ? ROLE_STROBE : ROLE_GPIO;
      end else begin : g_wide
        assign role_w[i] = ext_mode ? ROLE_STROBE : ROLE_GPIO;
      end
      assign strobe_val[i] = sw_stby ? strobe_hold[i-BUS_LO] : strobe_in[i-BUS_LO];
    end else begin : g_plain
      assign role_w[i]     = ROLE_GPIO;
      assign strobe_val[i] = 1'b0;
    end
  end

  always_comb begin
    for (int i = 0; i < PORT_W; i++) begin
      unique case (role_w[i])
        ROLE_CLOCK: begin
          pin_out[i]    = clk_src;
          pin_oe[i]     = 1'b1;
          gpio_drive[i] = 1'b0;
        end
        ROLE_STROBE: begin
          pin_out[i]    = strobe_val[i];
          pin_oe[i]     = strobe_en;
          gpio_drive[i] = 1'b0;
        end
        default: begin
          pin_out[i]    = data_q[i];
          pin_oe[i]     = dir_q[i];
          gpio_drive[i] = dir_q[i];
        end
      endcase
    end
  end

  // R8
  strobe_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && !sw_stby) |-> (&pin_oe[BUS_HI:BUS_LO+1]));

  // R9
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && sw_stby && !bus_keep) |-> (pin_oe[BUS_HI:BUS_LO+1] == '0));

  // R9
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && sw_stby && bus_keep && $past(sw_stby)) |->
      $stable(pin_out[BUS_HI:BUS_LO+1]));
endmodule

// File: rtl/gpio_mode_port.sv
module gpio_mode_port
  import gpio_port_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hw_stby,
  input  logic                sw_stby,
  input  logic                bus_keep,
  input  logic [2:0]          mode,
  input  logic                bus8,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [PORT_W-1:0]   wdata,
  output logic [PORT_W-1:0]   rdata,
  input  logic                clk_src,
  input  logic [BUS_N-1:0]    strobe_in,
  input  logic [PORT_W-1:0]   pin_in,
  output logic [PORT_W-1:0]   pin_out,
  output logic [PORT_W-1:0]   pin_oe
);
  reg_sel_e          sel;
  logic              ext_mode;
  logic [PORT_W-1:0] dir_q;
  logic [PORT_W-1:0] data_q;
  logic [PORT_W-1:0] pin_sync;
  logic [PORT_W-1:0] gpio_drive;
  logic [PORT_W-1:0] pin_view;

  assign sel      = reg_sel_e'(addr);
  assign ext_mode = is_ext_mode(mode);

  gpio_dir_reg u_dir (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_stby  (hw_stby),
    .sw_stby  (sw_stby),
    .ext_mode (ext_mode),
    .wr       (wr_en && (sel == SEL_DIR)),
    .wdata    (wdata),
    .dir_q    (dir_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      data_q <= '0;
    else if (wr_en && (sel == SEL_DATA) && !sw_stby)
      data_q <= wdata;
  end

  gpio_in_sync #(.W(PORT_W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  gpio_pin_mux u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_mode   (ext_mode),
    .bus8       (bus8),
    .sw_stby    (sw_stby),
    .bus_keep   (bus_keep),
    .dir_q      (dir_q),
    .data_q     (data_q),
    .clk_src    (clk_src),
    .strobe_in  (strobe_in),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .gpio_drive (gpio_drive)
  );

  assign pin_view = (data_q & gpio_drive) | (pin_sync & ~gpio_drive);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_DATA: rdata = data_q;
        SEL_PINS: rdata = pin_view;
        default:  rdata = '0;
      endcase
    end
  end

  // R4
  missing_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~DIR_IMPL) == '0);

  // R2
  dir_unreadable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_DIR) |-> rdata == '0);

  // R6
  single_chip_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode |-> pin_out == data_q);
endmodule

// File: tb/gpio_mode_port_test.sv
module gpio_mode_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_stby = 1'b0, sw_stby = 1'b0, bus_keep = 1'b0;
  logic [2:0] mode = 3'd7;
  logic       bus8 = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       clk_src = 1'b1;
  logic [3:0] strobe_in = 4'b1010;
  logic [7:0] pin_in = 8'h3C;
  logic [7:0] pin_out, pin_oe;

  int checks = 0;
  int bad = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  gpio_mode_port uut (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .bus_keep(bus_keep), .mode(mode), .bus8(bus8), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .clk_src(clk_src), .strobe_in(strobe_in), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  typedef struct packed {
    logic [2:0] mode;
    logic       bus8;
    logic [7:0] dir;
    logic [7:0] dat;
    logic [7:0] exp_oe;
    logic [7:0] exp_out;
    logic [7:0] exp_pins;
  } vec_t;

  // strobes 1010, clock source 1, pad inputs 0x3C
  localparam vec_t VECS [0:6] = '{
    '{3'd7, 1'b0, 8'hFF, 8'hA5, 8'hF9, 8'hA5, 8'hA5},
    '{3'd7, 1'b0, 8'h00, 8'h5A, 8'h00, 8'h5A, 8'h3C},
    '{3'd4, 1'b0, 8'hFF, 8'h00, 8'hF9, 8'hD0, 8'h3C},
    '{3'd5, 1'b0, 8'h00, 8'hFF, 8'h78, 8'hD7, 8'h3C},
    '{3'd6, 1'b1, 8'h08, 8'h00, 8'h78, 8'h50, 8'h34},
    '{3'd6, 1'b1, 8'h00, 8'h08, 8'h70, 8'h58, 8'h3C},
    '{3'd4, 1'b0, 8'h80, 8'h7F, 8'hF8, 8'hD7, 8'h3C}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] m);
    @(negedge clk);
    mode = m; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    // table walk: R6 R7 R8 R10 R2 R1
    foreach (VECS[k]) begin
      do_reset(VECS[k].mode);
      bus8 = VECS[k].bus8;
      reg_wr(2'd0, VECS[k].dir);
      reg_wr(2'd1, VECS[k].dat);
      check("R6/R7/R8 oe", pin_oe, VECS[k].exp_oe);
      check("R6/R7/R8 out", pin_out, VECS[k].exp_out);
      reg_rd(2'd2, rv); check("R10 pins", rv, VECS[k].exp_pins);
      reg_rd(2'd1, rv); check("R1 data", rv, VECS[k].dat);
      reg_rd(2'd0, rv); check("R2 dir read", rv, 8'h00);
    end
    bus8 = 1'b0;

    // R3 reset values seen on output enables; R1 data latch clear
    do_reset(3'd4);
    check("R3 ext reset oe", pin_oe, 8'hF8);
    reg_rd(2'd1, rv); check("R1 data reset", rv, 8'h00);
    do_reset(3'd7);
    check("R3 single reset oe", pin_oe, 8'h00);

    // R3 hardware standby reload
    reg_wr(2'd0, 8'hFF);
    check("R4 pins 2,1 never driven", pin_oe, 8'hF9);
    @(negedge clk); hw_stby = 1'b1;
    @(negedge clk); hw_stby = 1'b0;
    check("R3 hw reload mode7", pin_oe, 8'h00);
    do_reset(3'd4);
    reg_wr(2'd0, 8'h00);
    check("R3 ext dir cleared", pin_oe, 8'h78);
    @(negedge clk); hw_stby = 1'b1;
    @(negedge clk); hw_stby = 1'b0;
    check("R3 hw reload ext", pin_oe, 8'hF8);

    // R5 software standby retention, writes ignored
    do_reset(3'd7);
    reg_wr(2'd0, 8'h81);
    @(negedge clk); sw_stby = 1'b1;
    reg_wr(2'd0, 8'h00);
    reg_wr(2'd1, 8'h55);
    check("R5 dir kept", pin_oe, 8'h81);
    reg_rd(2'd1, rv); check("R5 data kept", rv, 8'h00);
    @(negedge clk); sw_stby = 1'b0;
    @(negedge clk);
    check("R5 dir after standby", pin_oe, 8'h81);

    // R9 release option
    do_reset(3'd4);
    strobe_in = 4'b1010;
    bus_keep = 1'b0;
    @(negedge clk); sw_stby = 1'b1;
    @(negedge clk);
    check("R9 strobes released", pin_oe, 8'h80);
    sw_stby = 1'b0;
    @(negedge clk);
    check("R9 strobes back", pin_oe, 8'hF8);

    // R9 keep option: hold the last pre-standby strobe levels
    bus_keep = 1'b1;
    @(negedge clk);
    sw_stby = 1'b1; strobe_in = 4'b0101;
    @(negedge clk);
    check("R9 keep oe", pin_oe, 8'hF8);
    check("R9 held strobes", pin_out & 8'h78, 8'h50);
    @(negedge clk); sw_stby = 1'b0;
    #1 check("R8 live strobes", pin_out & 8'h78, 8'h28);
    bus_keep = 1'b0;

    // R10 two-edge synchroniser latency
    do_reset(3'd7);
    repeat (3) @(negedge clk);
    pin_in = 8'h96;
    @(negedge clk);
    addr = 2'd2; rd_en = 1'b1;
    #1 check("R10 one edge", rdata, 8'h3C);
    @(negedge clk);
    #1 check("R10 two edges", rdata, 8'h96);
    rd_en = 1'b0;

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule